// File: doc/BRIEF.md
# Isochronous OUT Double-Buffer Receiver

This block is the receive side of a USB device endpoint running isochronous OUT transfers. The serial engine hands it decoded token fields, data bytes with valid and last strobes, and start-of-frame events that carry an 11-bit frame number. The block holds two packet buffers, A and B. One collects the current frame's packet. The other keeps the previous frame's packet for the CPU. The two swap roles on every start-of-frame, so the CPU always sees whole frames, one frame late.

During a transaction the block needs no help from the CPU. It checks the OUT token against the configured device address and endpoint, and it checks that the endpoint is set up for isochronous OUT. It then stores the payload of the DATA0 packet that follows and verifies the packet's CRC16. The result goes into a status register. Between start-of-frame events the CPU reads the held buffer through a byte read port, together with per-buffer byte counts, data-ready flags and the frame register.

Top module: `iso_out_pingpong`

## Requirements
- R1: After reset, status_o is 0 (no result), rdy_o is 2'b00, frame_o is 0, both size outputs are 0 and sof_o is 0. Buffer A is the receiving buffer.
- R2: Tokens are 4-bit PIDs, with OUT = 4'b0001 and DATA0 = 4'b0011. An accepted OUT token followed by a DATA0 token opens a packet. Every byte of that packet except the final two (the CRC, low byte first) is stored in the receiving buffer from address 0 upward. The buffer's size output takes the stored byte count at the clock edge that samples the last byte.
- R3: An OUT token whose address or endpoint number differs from cfg_addr_i or cfg_ep_i is dropped. The packet that follows leaves status and buffers untouched.
- R4: An OUT token that matches but arrives while cfg_iso_i is 0 is dropped in the same way.
- R5: If the complement of the CRC16 over the payload (polynomial x^16+x^15+x^2+1, LSB first, initial value 0xFFFF) equals the received CRC, status_o becomes 1 (DATAIN) at the edge that samples the last byte.
- R6: On a CRC mismatch, status_o becomes 2 (RX_ERR). The payload bytes and the byte count are still kept.
- R7: Each buffer holds DEPTH (64) bytes. Payload bytes beyond DEPTH are discarded, the count stops at DEPTH, and status_o becomes 2 even when the CRC is good.
- R8: On sof_i the receiving buffer becomes the held buffer. The held buffer becomes the receiving buffer, and its contents and count are cleared to 0.
- R9: sof_i loads sof_frame_i into frame_o and raises sof_o for exactly the one following cycle.
- R10: An sof_i during packet reception aborts the packet. Status and the aborted buffer's count are left unchanged, and later bytes are ignored until a new OUT token is accepted.
- R11: Data bytes outside an open packet are ignored. After an accepted OUT token, any PID other than DATA0 returns the block to idle.
- R12: After each sof_i, rdy_o has exactly one bit set, and that bit marks the held buffer (bit 0 = A, bit 1 = B). The buffers alternate, starting with A held after the first start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_addr_i | input | 7 | Configured device address |
| cfg_ep_i | input | 4 | Configured endpoint number |
| cfg_iso_i | input | 1 | Endpoint is configured for isochronous OUT |
| tok_valid_i | input | 1 | Token strobe |
| tok_pid_i | input | 4 | Token PID |
| tok_addr_i | input | 7 | Token device address |
| tok_ep_i | input | 4 | Token endpoint number |
| rx_valid_i | input | 1 | Data byte strobe |
| rx_data_i | input | 8 | Data byte |
| rx_last_i | input | 1 | Marks the final byte of the packet |
| sof_i | input | 1 | Start-of-frame strobe |
| sof_frame_i | input | 11 | Frame number carried with sof_i |
| rd_addr_i | input | 6 | Read address into the held buffer |
| rd_data_o | output | 8 | Held buffer byte at rd_addr_i |
| size_a_o | output | 7 | Byte count of buffer A |
| size_b_o | output | 7 | Byte count of buffer B |
| rdy_o | output | 2 | Data-ready flags, bit 0 = A, bit 1 = B |
| status_o | output | 2 | 0 none, 1 DATAIN, 2 RX_ERR |
| frame_o | output | 11 | Last received frame number |
| sof_o | output | 1 | One-cycle start-of-frame indication |

## Verification
A wrong role bit shows up after the next start-of-frame. The rdy_o flag points at the wrong buffer and rd_data_o returns stale or cleared bytes, so each swap is checked by reading back the held payload. A CRC pipeline that is off by one byte stores a CRC byte as payload or loses a payload byte. That appears as a wrong size count and a wrong status at the edge that samples the last byte. A missing abort or a bad token filter shows up as a size count or status that changes when it must not, and that is checked right after the stimulus.

// File: rtl/iso_out_pkg.sv
package iso_out_pkg;

  typedef enum logic [1:0] {
    RX_NONE   = 2'd0,
    RX_DATAIN = 2'd1,
    RX_ERR    = 2'd2
  } rx_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_RECV = 2'd2
  } rx_state_e;

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_DATA0 = 4'b0011;

  // reflected CRC16, LSB-first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/iso_rx_ctrl.sv
module iso_rx_ctrl
  import iso_out_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned EP_W   = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [EP_W-1:0]   cfg_ep_i,
  input  logic              cfg_iso_i,
  input  logic              tok_valid_i,
  input  logic [3:0]        tok_pid_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              sof_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o,
  output logic              done_ok_o,
  output logic [CW-1:0]     done_size_o
);

  rx_state_e   state_q;
  logic [1:0]  pend_q;
  logic [7:0]  d0_q, d1_q;
  logic [15:0] crc_q;
  logic [CW-1:0] wptr_q;
  logic        ovf_q;

  logic        byte_in, push, ovf_now, tok_match;
  logic [15:0] crc_push, crc_fin, rx_crc;

  assign tok_match = (tok_addr_i == cfg_addr_i) && (tok_ep_i == cfg_ep_i) && cfg_iso_i;
  assign byte_in   = (state_q == S_RECV) && rx_valid_i && !sof_i;
  assign push      = byte_in && (pend_q == 2'd2);
  assign crc_push  = crc16_step(crc_q, d0_q);

  always_comb begin
    wr_en_o   = push && (wptr_q < CW'(DEPTH));
    wr_addr_o = wptr_q[AW-1:0];
    wr_data_o = d0_q;
    crc_fin   = push ? crc_push : crc_q;
    rx_crc    = (pend_q == 2'd2) ? {rx_data_i, d1_q} : {rx_data_i, d0_q};
    ovf_now   = ovf_q || (push && !wr_en_o);
    done_o    = byte_in && rx_last_i;
    done_ok_o = (pend_q != 2'd0) && !ovf_now && ((~crc_fin) == rx_crc);
    done_size_o = wptr_q + (wr_en_o ? CW'(1) : CW'(0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      crc_q   <= 16'hFFFF;
      wptr_q  <= '0;
      ovf_q   <= 1'b0;
    end else if (sof_i) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (tok_valid_i && tok_pid_i == PID_OUT && tok_match) state_q <= S_WAIT;
        S_WAIT: if (tok_valid_i) begin
          state_q <= (tok_pid_i == PID_DATA0) ? S_RECV : S_IDLE;
          pend_q  <= '0;
          crc_q   <= 16'hFFFF;
          wptr_q  <= '0;
          ovf_q   <= 1'b0;
        end
        S_RECV: if (rx_valid_i) begin
          if (rx_last_i) begin
            state_q <= S_IDLE;
          end else if (pend_q == 2'd2) begin
            d0_q  <= d1_q;
            d1_q  <= rx_data_i;
            crc_q <= crc_push;
            if (wr_en_o) wptr_q <= wptr_q + CW'(1);
            else         ovf_q  <= 1'b1;
          end else if (pend_q == 2'd1) begin
            d1_q   <= rx_data_i;
            pend_q <= 2'd2;
          end else begin
            d0_q   <= rx_data_i;
            pend_q <= 2'd1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_wptr_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= CW'(DEPTH));
  p_sof_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> state_q == S_IDLE);
  p_ovf_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovf_q) |-> !done_ok_o);

endmodule

// File: rtl/iso_pkt_bank.sv
module iso_pkt_bank #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          ld_en_i,
  input  logic [CW-1:0] ld_size_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] size_a_o,
  output logic [CW-1:0] size_b_o,
  output logic [1:0]    rdy_o
);

  logic       rx_sel_q;   // index of receiving buffer
  logic [1:0] rdy_q;
  logic [7:0]    rd_byte [2];
  logic [CW-1:0] size_w  [2];

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [7:0]    mem_q [DEPTH];
    logic [CW-1:0] size_q;
    logic is_rx, clr;
    assign is_rx = (rx_sel_q == 1'(b));
    assign clr   = sof_i && !is_rx;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        size_q <= '0;
      end else if (clr) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        size_q <= '0;
      end else if (!sof_i && is_rx) begin
        if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
        if (ld_en_i) size_q <= ld_size_i;
      end
    end

    assign rd_byte[b] = mem_q[rd_addr_i];
    assign size_w[b]  = size_q;

    p_size_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      size_q <= CW'(DEPTH));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sel_q <= 1'b0;
      rdy_q    <= 2'b00;
    end else if (sof_i) begin
      rx_sel_q <= ~rx_sel_q;
      rdy_q    <= rx_sel_q ? 2'b10 : 2'b01;
    end
  end

  assign rd_data_o = rd_byte[~rx_sel_q];
  assign size_a_o  = size_w[0];
  assign size_b_o  = size_w[1];
  assign rdy_o     = rdy_q;

  p_rdy_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> $countones(rdy_o) == 1);
  p_rdy_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o != 2'b00) |-> !rdy_o[rx_sel_q]);
  p_swap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> rx_sel_q != $past(rx_sel_q));

endmodule

// File: rtl/iso_out_pingpong.sv
module iso_out_pingpong
  import iso_out_pkg::*;
#(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned EP_W    = 4,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [EP_W-1:0]    cfg_ep_i,
  input  logic               cfg_iso_i,
  input  logic               tok_valid_i,
  input  logic [3:0]         tok_pid_i,
  input  logic [ADDR_W-1:0]  tok_addr_i,
  input  logic [EP_W-1:0]    tok_ep_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_last_i,
  input  logic               sof_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [7:0]         rd_data_o,
  output logic [CW-1:0]      size_a_o,
  output logic [CW-1:0]      size_b_o,
  output logic [1:0]         rdy_o,
  output logic [1:0]         status_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sof_o
);

  logic          wr_en, done, done_ok;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [CW-1:0] done_size;

  rx_status_e         status_q;
  logic [FRAME_W-1:0] frame_q;
  logic               sof_q;

  iso_rx_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .EP_W(EP_W)) u_ctrl (
    .clk_i, .rst_ni, .cfg_addr_i, .cfg_ep_i, .cfg_iso_i,
    .tok_valid_i, .tok_pid_i, .tok_addr_i, .tok_ep_i,
    .rx_valid_i, .rx_data_i, .rx_last_i, .sof_i,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .done_ok_o(done_ok), .done_size_o(done_size)
  );

  iso_pkt_bank #(.DEPTH(DEPTH)) u_bank (
    .clk_i, .rst_ni, .sof_i,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ld_en_i(done), .ld_size_i(done_size),
    .rd_addr_i, .rd_data_o, .size_a_o, .size_b_o, .rdy_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= RX_NONE;
      frame_q  <= '0;
      sof_q    <= 1'b0;
    end else begin
      sof_q <= sof_i;
      if (sof_i) frame_q <= sof_frame_i;
      if (done)  status_q <= done_ok ? RX_DATAIN : RX_ERR;
    end
  end

  assign status_o = status_q;
  assign frame_o  = frame_q;
  assign sof_o    = sof_q;

  p_sof_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> sof_o);
  p_sof_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> !sof_o);
  p_frame_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> frame_o == $past(sof_frame_i));
  p_status_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> status_o == $past(status_o));

endmodule

// File: tb/iso_out_pingpong_test.sv
module iso_out_pingpong_test;

  localparam int DEPTH = 64;
  localparam logic [6:0] MY_ADDR = 7'h2A;
  localparam logic [3:0] MY_EP   = 4'h3;
  localparam logic [3:0] P_OUT = 4'b0001, P_D0 = 4'b0011, P_D1 = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] cfg_addr = MY_ADDR;
  logic [3:0] cfg_ep = MY_EP;
  logic cfg_iso = 1'b1;
  logic tok_valid = 0; logic [3:0] tok_pid = 0; logic [6:0] tok_addr = 0; logic [3:0] tok_ep = 0;
  logic rx_valid = 0; logic [7:0] rx_data = 0; logic rx_last = 0;
  logic sof = 0; logic [10:0] sof_frame = 0;
  logic [5:0] rd_addr = 0;
  logic [7:0] rd_data; logic [6:0] size_a, size_b;
  logic [1:0] rdy, status; logic [10:0] frame; logic sof_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] pkt [80];

  always #5 clk = ~clk;

  iso_out_pingpong uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_addr_i(cfg_addr), .cfg_ep_i(cfg_ep), .cfg_iso_i(cfg_iso),
    .tok_valid_i(tok_valid), .tok_pid_i(tok_pid), .tok_addr_i(tok_addr), .tok_ep_i(tok_ep),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .sof_i(sof), .sof_frame_i(sof_frame), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .size_a_o(size_a), .size_b_o(size_b), .rdy_o(rdy), .status_o(status),
    .frame_o(frame), .sof_o(sof_out)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic fb = c[0] ^ pkt[i][k];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'hA001;
      end
    return ~c;
  endfunction

  task automatic fill(int seed, int n);
    for (int i = 0; i < n; i++) pkt[i] = 8'(seed + i * 37 + 1);
  endtask

  task automatic token(logic [3:0] pid, logic [6:0] a, logic [3:0] e);
    @(negedge clk); tok_valid = 1; tok_pid = pid; tok_addr = a; tok_ep = e;
    @(negedge clk); tok_valid = 0;
  endtask

  task automatic bytes(int n, bit bad);
    logic [15:0] c = ref_crc(n);
    if (bad) c = c ^ 16'h0100;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_last = (i == n + 1);
      rx_data = (i < n) ? pkt[i] : (i == n) ? c[7:0] : c[15:8];
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic packet(int n, bit bad);
    token(P_OUT, MY_ADDR, MY_EP);
    token(P_D0, 7'h0, 4'h0);
    bytes(n, bad);
  endtask

  task automatic do_sof(int f, int exp_rdy);
    @(negedge clk); sof = 1; sof_frame = 11'(f);
    @(negedge clk); sof = 0;
    chk("R9 sof_o pulse", sof_out, 1);
    chk("R9 frame", frame, f);
    chk("R12 rdy", rdy, exp_rdy);
    @(negedge clk);
    chk("R9 sof_o single", sof_out, 0);
  endtask

  task automatic read_held(string req, int n);
    for (int i = 0; i < n; i++) begin
      rd_addr = 6'(i); #1;
      chk(req, rd_data, pkt[i]);
    end
  endtask

  task automatic t_reset;
    chk("R1 status", status, 0); chk("R1 rdy", rdy, 0); chk("R1 frame", frame, 0);
    chk("R1 size_a", size_a, 0); chk("R1 size_b", size_b, 0); chk("R1 sof_o", sof_out, 0);
  endtask

  task automatic t_good;   // B receiving
    fill(3, 10); packet(10, 0);
    chk("R5 status DATAIN", status, 1);
    chk("R2 size_b", size_b, 10);
    do_sof(6, 2'b10);
    read_held("R2 held data", 10);
    chk("R8 size_a cleared", size_a, 0);
  endtask

  task automatic t_bad;    // A receiving
    fill(11, 5); packet(5, 1);
    chk("R6 status RX_ERR", status, 2);
    chk("R6 size_a kept", size_a, 5);
    do_sof(7, 2'b01);
    read_held("R6 data kept", 5);
    chk("R8 size_b cleared", size_b, 0);
  endtask

  task automatic t_filter; // B receiving, status 2
    fill(20, 4);
    token(P_OUT, MY_ADDR ^ 7'h1, MY_EP); token(P_D0, 0, 0); bytes(4, 0);
    chk("R3 addr mismatch status", status, 2); chk("R3 addr mismatch size", size_b, 0);
    token(P_OUT, MY_ADDR, MY_EP + 4'h1); token(P_D0, 0, 0); bytes(4, 0);
    chk("R3 ep mismatch status", status, 2); chk("R3 ep mismatch size", size_b, 0);
    cfg_iso = 0;
    packet(4, 0);
    chk("R4 non-iso status", status, 2); chk("R4 non-iso size", size_b, 0);
    cfg_iso = 1;
    token(P_OUT, MY_ADDR, MY_EP); token(P_D1, 0, 0); bytes(4, 0);
    chk("R11 DATA1 status", status, 2); chk("R11 DATA1 size", size_b, 0);
    bytes(4, 0);
    chk("R11 stray bytes", size_b, 0);
  endtask

  task automatic t_overflow; // B receiving
    fill(40, 3); packet(3, 0);
    chk("R5 status DATAIN", status, 1);
    fill(50, 70); packet(70, 0);
    chk("R7 status RX_ERR", status, 2);
    chk("R7 size saturated", size_b, DEPTH);
    do_sof(8, 2'b10);
    read_held("R7 first bytes kept", DEPTH);
  endtask

  task automatic t_abort;  // A receiving
    fill(60, 2); packet(2, 0);
    chk("R5 status DATAIN", status, 1);
    chk("R2 size_a", size_a, 2);
    fill(70, 8);
    token(P_OUT, MY_ADDR, MY_EP); token(P_D0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = pkt[i];
    end
    @(negedge clk); rx_data = pkt[3]; sof = 1; sof_frame = 11'd9;
    @(negedge clk); rx_valid = 0; sof = 0;
    chk("R10 status unchanged", status, 1);
    chk("R10 size unchanged", size_a, 2);
    chk("R12 rdy after abort", rdy, 2'b01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = pkt[i]; rx_last = (i == 3);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
    chk("R10 later bytes ignored", size_b, 0);
    chk("R10 status after stray", status, 1);
  endtask

  task automatic t_clear;  // B receiving, A held
    do_sof(10, 2'b10);
    chk("R8 size_a cleared", size_a, 0);
    do_sof(11, 2'b01);
    rd_addr = 0; #1;
    chk("R8 contents cleared", rd_data, 0);
    chk("R8 held size zero", size_a, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    do_sof(5, 2'b01);   // R12: A held first
    t_good();
    t_bad();
    t_filter();
    t_overflow();
    t_abort();
    t_clear();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule